// File: doc/BRIEF.md
# Embedded Sync Code Framer

This block takes a recovered serial bit stream, with one bit per cycle in which `bit_vld` is high and each byte sent least significant bit first. It searches that stream for 32-bit embedded synchronisation codes. A code is the three bytes FF, 00, 00 followed by a descriptor byte. The low nibble of the descriptor gives the code kind and the high nibble gives a logical channel. The first valid code fixes the byte boundary. From then on, the block emits parallel bytes with a one-cycle strobe, and drives horizontal and vertical sync levels plus the channel number of the most recent code.

Bytes pass through a four-entry delay line. This lets a code be recognised in full before any of its bytes leaves the block. In stripped mode (`strip_sel` high) all four code bytes are withheld from the output. In pass-through mode they appear as ordinary bytes. The sync levels change at the moment the descriptor byte leaves the delay line. Pulling `en` low clears all outputs and all internal state, so after `en` returns the block must find a code again before it emits anything.

Top module: `embedded_sync_framer`

## Requirements
- R1: A code is recognised when the last 32 received bits, taken least significant bit first, form the bytes FF, 00, 00, D in that order of arrival. The first serial bit of a code is bit 0 of the FF byte.
- R2: A descriptor low nibble of 0 (line start) drives `hsync` high, and 1 (line end) drives it low. Neither changes `vsync`.
- R3: Descriptor kind 2 (frame start) drives both `vsync` and `hsync` high. Kind 3 (frame end) drives both low.
- R4: The descriptor high nibble (0 to 7) is loaded into `chan_id` together with the level change. A pattern whose channel nibble exceeds 7 or whose kind nibble exceeds 3 is treated as four data bytes.
- R5: No byte strobe occurs until the first valid code has been seen. The first code may start at any bit offset, and it sets the byte boundary.
- R6: A later code at a different bit offset moves the byte boundary, and the following bytes are assembled on the new boundary.
- R7: With `strip_sel` high, none of the four bytes of a valid code is strobed. Data bytes are strobed in order and carry the levels set by the preceding code.
- R8: With `strip_sel` low, every byte after lock is strobed in order, code bytes included. The levels change on the strobe that carries the descriptor byte.
- R9: A byte leaves the block only when four more bytes have completed behind it, so the last four bytes of a burst stay held inside.
- R10: While `en` is low, `byte_out`, `byte_stb`, `hsync`, `vsync` and `chan_id` are zero from the next cycle on. Lock is lost.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Operate when high; clears the block when low |
| strip_sel | input | 1 | 1: withhold code bytes, 0: pass them through |
| bit_vld | input | 1 | `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Serial data bit |
| byte_out | output | 8 | Assembled byte |
| byte_stb | output | 1 | One-cycle strobe for `byte_out` |
| hsync | output | 1 | Line active level |
| vsync | output | 1 | Frame active level |
| chan_id | output | 3 | Channel of the most recent code |

## Verification
The assertions expect `en` and `strip_sel` to be synchronous levels, and expect bits to count only in cycles where `bit_vld` is high. They assume nothing about the order in which codes arrive. The stimulus changes inputs only on the falling clock edge and runs with and without idle cycles between bits. Outside the deliberately malformed descriptors, the data bytes are chosen so that no run of eight ones followed by sixteen zeros can appear across byte boundaries.

// File: rtl/esf_pkg.sv
package esf_pkg;
  typedef enum logic [1:0] {
    KIND_LINE_OPEN   = 2'd0,
    KIND_LINE_CLOSE  = 2'd1,
    KIND_FRAME_OPEN  = 2'd2,
    KIND_FRAME_CLOSE = 2'd3
  } sync_kind_e;

  localparam int unsigned DEF_BYTE_W     = 8;
  localparam int unsigned DEF_CODE_BYTES = 4;
  localparam int unsigned DEF_MAX_CHAN   = 7;
  localparam int unsigned DEF_MAX_KIND   = 3;
endpackage

// File: rtl/esf_matcher.sv
module esf_matcher #(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned CODE_BYTES = 4,
  parameter int unsigned MAX_CHAN   = 7,
  parameter int unsigned MAX_KIND   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic              match,
  output logic [BYTE_W-1:0] new_byte
);
  localparam int unsigned CODE_W = BYTE_W * CODE_BYTES;
  localparam int unsigned NIB_W  = BYTE_W / 2;

  logic [CODE_W-1:0]     win_q, win_n;
  logic [CODE_BYTES-2:0] pre_ok;
  logic [NIB_W-1:0]      kind_nib, chan_nib;

  // New bits enter at the top, so the oldest byte ends at the bottom.
  assign win_n = {bit_in, win_q[CODE_W-1:1]};

  generate
    for (genvar b = 0; b < CODE_BYTES - 1; b++) begin : g_prefix
      if (b == 0) begin : g_ones
        assign pre_ok[b] = &win_n[b*BYTE_W +: BYTE_W];
      end else begin : g_zeros
        assign pre_ok[b] = ~|win_n[b*BYTE_W +: BYTE_W];
      end
    end
  endgenerate

  assign new_byte = win_n[CODE_W-1 -: BYTE_W];
  assign kind_nib = new_byte[NIB_W-1:0];
  assign chan_nib = new_byte[BYTE_W-1 -: NIB_W];
  assign match    = en && bit_vld && (&pre_ok)
                    && (kind_nib <= NIB_W'(MAX_KIND))
                    && (chan_nib <= NIB_W'(MAX_CHAN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (!en) begin
      win_q <= '0;
    end else if (bit_vld) begin
      win_q <= win_n;
    end
  end
endmodule

// File: rtl/esf_aligner.sv
module esf_aligner #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bit_vld,
  input  logic match,
  output logic tick,
  output logic same_phase,
  output logic locked
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             lock_q, lock_n;
  logic             wrap;

  assign wrap       = (cnt_q == CNT_W'(BYTE_W - 1));
  assign same_phase = lock_q && wrap;
  assign tick       = bit_vld && (match || same_phase);
  assign locked     = lock_q;

  always_comb begin
    cnt_n  = cnt_q;
    lock_n = lock_q;
    if (match) begin
      cnt_n  = '0;
      lock_n = 1'b1;
    end else begin
      cnt_n = wrap ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (!en) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (bit_vld) begin
      cnt_q  <= cnt_n;
      lock_q <= lock_n;
    end
  end

  assert_lock_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && en) |=> lock_q);
endmodule

// File: rtl/esf_delay.sv
module esf_delay #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              match,
  input  logic              same_phase,
  input  logic [BYTE_W-1:0] new_byte,
  output logic              fire,
  output logic [BYTE_W-1:0] out_dat,
  output logic              out_code,
  output logic              out_last
);
  logic [DEPTH-1:0][BYTE_W-1:0] dat_q, dat_n;
  logic [DEPTH-1:0]             vld_q, vld_n, cod_q, cod_n, lst_q, lst_n;

  always_comb begin
    dat_n    = dat_q;
    vld_n    = vld_q;
    cod_n    = cod_q;
    lst_n    = lst_q;
    dat_n[0] = new_byte;
    vld_n[0] = 1'b1;
    cod_n[0] = match;
    lst_n[0] = match;
    for (int i = 1; i < DEPTH; i++) begin
      if (match) begin
        // The match proves the older bytes on the new boundary.
        dat_n[i] = (i == DEPTH - 1) ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}};
        vld_n[i] = 1'b1;
        cod_n[i] = 1'b1;
        lst_n[i] = 1'b0;
      end else begin
        dat_n[i] = dat_q[i-1];
        vld_n[i] = vld_q[i-1];
        cod_n[i] = cod_q[i-1];
        lst_n[i] = lst_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      vld_q <= '0;
      cod_q <= '0;
      lst_q <= '0;
    end else if (!en) begin
      dat_q <= '0;
      vld_q <= '0;
      cod_q <= '0;
      lst_q <= '0;
    end else if (tick) begin
      dat_q <= dat_n;
      vld_q <= vld_n;
      cod_q <= cod_n;
      lst_q <= lst_n;
    end
  end

  assign fire     = tick && same_phase && vld_q[DEPTH-1];
  assign out_dat  = dat_q[DEPTH-1];
  assign out_code = cod_q[DEPTH-1];
  assign out_last = lst_q[DEPTH-1];

  assert_prefix_loaded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match) |=> (cod_q[DEPTH-1] && (dat_q[DEPTH-1] == {BYTE_W{1'b1}})
                         && lst_q[0]));
endmodule

// File: rtl/embedded_sync_framer.sv
module embedded_sync_framer
  import esf_pkg::*;
#(
  parameter int unsigned BYTE_W     = DEF_BYTE_W,
  parameter int unsigned CODE_BYTES = DEF_CODE_BYTES,
  parameter int unsigned MAX_CHAN   = DEF_MAX_CHAN,
  parameter int unsigned MAX_KIND   = DEF_MAX_KIND,
  parameter int unsigned CHAN_W     = $clog2(MAX_CHAN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              strip_sel,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_stb,
  output logic              hsync,
  output logic              vsync,
  output logic [CHAN_W-1:0] chan_id
);
  localparam int unsigned NIB_W = BYTE_W / 2;

  logic              match, tick, same_phase, locked;
  logic              fire, out_code, out_last;
  logic [BYTE_W-1:0] new_byte, out_dat;
  sync_kind_e        kind;

  logic [BYTE_W-1:0] byte_q, byte_n;
  logic              stb_q, stb_n, hs_q, hs_n, vs_q, vs_n;
  logic [CHAN_W-1:0] chan_q, chan_n;

  esf_matcher #(
    .BYTE_W(BYTE_W), .CODE_BYTES(CODE_BYTES),
    .MAX_CHAN(MAX_CHAN), .MAX_KIND(MAX_KIND)
  ) u_match (
    .clk(clk), .rst_n(rst_n), .en(en), .bit_vld(bit_vld), .bit_in(bit_in),
    .match(match), .new_byte(new_byte)
  );

  esf_aligner #(.BYTE_W(BYTE_W)) u_align (
    .clk(clk), .rst_n(rst_n), .en(en), .bit_vld(bit_vld), .match(match),
    .tick(tick), .same_phase(same_phase), .locked(locked)
  );

  esf_delay #(.BYTE_W(BYTE_W), .DEPTH(CODE_BYTES)) u_delay (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .match(match),
    .same_phase(same_phase), .new_byte(new_byte), .fire(fire),
    .out_dat(out_dat), .out_code(out_code), .out_last(out_last)
  );

  assign kind = sync_kind_e'(out_dat[1:0]);

  always_comb begin
    byte_n = byte_q;
    stb_n  = 1'b0;
    hs_n   = hs_q;
    vs_n   = vs_q;
    chan_n = chan_q;
    if (fire) begin
      if (!strip_sel || !out_code) begin
        byte_n = out_dat;
        stb_n  = 1'b1;
      end
      if (out_last) begin
        chan_n = out_dat[NIB_W +: CHAN_W];
        unique case (kind)
          KIND_LINE_OPEN:   hs_n = 1'b1;
          KIND_LINE_CLOSE:  hs_n = 1'b0;
          KIND_FRAME_OPEN:  begin vs_n = 1'b1; hs_n = 1'b1; end
          KIND_FRAME_CLOSE: begin vs_n = 1'b0; hs_n = 1'b0; end
          default:          hs_n = hs_q;
        endcase
      end
    end
    if (!en) begin
      byte_n = '0;
      stb_n  = 1'b0;
      hs_n   = 1'b0;
      vs_n   = 1'b0;
      chan_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      stb_q  <= 1'b0;
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      chan_q <= '0;
    end else begin
      byte_q <= byte_n;
      stb_q  <= stb_n;
      hs_q   <= hs_n;
      vs_q   <= vs_n;
      chan_q <= chan_n;
    end
  end

  assign byte_out = byte_q;
  assign byte_stb = stb_q;
  assign hsync    = hs_q;
  assign vsync    = vs_q;
  assign chan_id  = chan_q;

  assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (byte_out == '0 && !byte_stb && !hsync && !vsync && chan_id == '0));
  assert_frame_opens_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> hsync);
  assert_frame_closes_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync) |-> !hsync);
  assert_strobe_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> ($past(tick) && $past(locked)));
endmodule

// File: tb/embedded_sync_framer_bench.sv
module embedded_sync_framer_bench;
  logic       clk = 1'b0;
  logic       rst_n, en, strip_sel, bit_vld, bit_in;
  logic [7:0] byte_out;
  logic       byte_stb, hsync, vsync;
  logic [2:0] chan_id;

  always #10 clk = ~clk;

  embedded_sync_framer u_embedded_sync_framer (
    .clk(clk), .rst_n(rst_n), .en(en), .strip_sel(strip_sel),
    .bit_vld(bit_vld), .bit_in(bit_in), .byte_out(byte_out),
    .byte_stb(byte_stb), .hsync(hsync), .vsync(vsync), .chan_id(chan_id)
  );

  // {byte, code member, hsync, vsync, channel} seen at that byte's strobe
  localparam int NV = 29;
  localparam logic [13:0] TBL [NV] = '{
    {8'hFF,1'b1,1'b0,1'b0,3'd0}, {8'h00,1'b1,1'b0,1'b0,3'd0},
    {8'h00,1'b1,1'b0,1'b0,3'd0}, {8'h22,1'b1,1'b1,1'b1,3'd2},
    {8'h11,1'b0,1'b1,1'b1,3'd2}, {8'h22,1'b0,1'b1,1'b1,3'd2},
    {8'hFF,1'b1,1'b1,1'b1,3'd2}, {8'h00,1'b1,1'b1,1'b1,3'd2},
    {8'h00,1'b1,1'b1,1'b1,3'd2}, {8'h21,1'b1,1'b0,1'b1,3'd2},
    {8'h33,1'b0,1'b0,1'b1,3'd2}, {8'hFF,1'b1,1'b0,1'b1,3'd2},
    {8'h00,1'b1,1'b0,1'b1,3'd2}, {8'h00,1'b1,1'b0,1'b1,3'd2},
    {8'h50,1'b1,1'b1,1'b1,3'd5}, {8'h44,1'b0,1'b1,1'b1,3'd5},
    {8'hFF,1'b0,1'b1,1'b1,3'd5}, {8'h00,1'b0,1'b1,1'b1,3'd5},
    {8'h00,1'b0,1'b1,1'b1,3'd5}, {8'h85,1'b0,1'b1,1'b1,3'd5},
    {8'hFF,1'b0,1'b1,1'b1,3'd5}, {8'h00,1'b0,1'b1,1'b1,3'd5},
    {8'h00,1'b0,1'b1,1'b1,3'd5}, {8'h14,1'b0,1'b1,1'b1,3'd5},
    {8'hFF,1'b1,1'b1,1'b1,3'd5}, {8'h00,1'b1,1'b1,1'b1,3'd5},
    {8'h00,1'b1,1'b1,1'b1,3'd5}, {8'h53,1'b1,1'b0,1'b0,3'd5},
    {8'h66,1'b0,1'b0,1'b0,3'd5}
  };

  int n_chk = 0, n_fail = 0, gap = 0, ncap = 0;
  bit finished = 0;
  logic [7:0] cap_b [64];
  logic [4:0] cap_l [64];

  always @(negedge clk) begin
    if (byte_stb && ncap < 64) begin
      cap_b[ncap] = byte_out;
      cap_l[ncap] = {hsync, vsync, chan_id};
      ncap++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b; bit_vld = 1'b1;
    repeat (gap) begin @(negedge clk); bit_vld = 1'b0; end
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int k = 0; k < 8; k++) send_bit(v[k]);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); bit_vld = 1'b0; end
  endtask

  task automatic restart;
    @(negedge clk); en = 1'b0; bit_vld = 1'b0;
    idle(2); en = 1'b1; ncap = 0;
  endtask

  task automatic run_table(input logic strip);
    int k = 0;
    strip_sel = strip;
    restart();
    for (int j = 0; j < 3; j++) send_bit(1'b1);
    for (int i = 0; i < NV; i++) send_byte(TBL[i][13:6]);
    for (int i = 0; i < 4; i++) send_byte(8'h77);
    idle(4);
    for (int i = 0; i < NV; i++) begin
      if (!strip || !TBL[i][5]) begin
        string tag;
        tag = (i >= 16 && i <= 23) ? "R4 invalid descriptor as data" :
              (strip ? "R7 stripped byte" : "R8 passed byte");
        check(cap_b[k] == TBL[i][13:6], tag, cap_b[k], TBL[i][13:6]);
        check(cap_l[k][4:3] == TBL[i][4:3], "R2 R3 levels at strobe",
              cap_l[k][4:3], TBL[i][4:3]);
        check(cap_l[k][2:0] == TBL[i][2:0], "R4 channel at strobe",
              cap_l[k][2:0], TBL[i][2:0]);
        k++;
      end
    end
    check(ncap == k, "R9 held tail bytes", ncap, k);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b1; strip_sel = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check({byte_out, byte_stb, hsync, vsync, chan_id} == '0, "R11 reset outputs",
          {byte_out, byte_stb, hsync, vsync, chan_id}, 0);

    // R5: data without any code produces no strobe
    ncap = 0;
    for (int i = 0; i < 8; i++) send_byte(8'h5A ^ 8'(i));
    idle(3);
    check(ncap == 0, "R5 no output before lock", ncap, 0);

    run_table(1'b0);
    run_table(1'b1);

    // R10: enable low clears outputs and lock
    strip_sel = 1'b0;
    restart();
    send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00); send_byte(8'h32);
    for (int i = 0; i < 4; i++) send_byte(8'h77);
    idle(3);
    check(hsync && vsync && chan_id == 3'd3, "R3 frame start levels",
          {hsync, vsync, chan_id}, 5'h1B);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    ncap = 0;
    for (int j = 0; j < 16; j++) begin
      send_bit(j[0]);
      check({byte_out, byte_stb, hsync, vsync, chan_id} == '0, "R10 outputs low",
            {byte_out, byte_stb, hsync, vsync, chan_id}, 0);
    end
    @(negedge clk); en = 1'b1;
    for (int i = 0; i < 6; i++) send_byte(8'h3C + 8'(i));
    idle(3);
    check(ncap == 0 && !hsync, "R10 lock lost after disable", ncap, 0);

    // R6: realign on a code at a new bit offset, with idle gaps
    strip_sel = 1'b1; gap = 1;
    restart();
    send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00); send_byte(8'h12);
    send_byte(8'hAA);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00); send_byte(8'h10);
    send_byte(8'hBB);
    for (int i = 0; i < 4; i++) send_byte(8'h77);
    idle(4);
    check(ncap == 2, "R6 strobe count after realign", ncap, 2);
    check(cap_b[0] == 8'hAA, "R6 byte before realign", cap_b[0], 8'hAA);
    check(cap_b[1] == 8'hBB, "R6 byte on new boundary", cap_b[1], 8'hBB);
    check(cap_l[1] == 5'b11001, "R2 line start keeps levels",
          cap_l[1], 5'b11001);
    gap = 0;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule